// File: doc/BRIEF.md
# Entropy Sampling Sequencer

This block turns a stream of raw noise bits into 64-bit random words that software can read. A noise source outside the block presents one bit per clock on `entropy_in`. The sequencer takes a sample from that stream once every D+1 clocks. After software sets the run bit, the block takes a programmable number of warm-up samples. It then captures the most recent 64 samples as an output word and raises a ready flag.

Software reads the word as a low half and a high half, then writes an acknowledge. The acknowledge drops the flag and starts a refill. A refill gathers fresh samples until a lower bound is met. It also stops at an upper bound if that bound is reached first. The next word then appears. An interrupt line reports the ready flag when the mask bit allows it.

The register port is synchronous. Writes take effect at the clock edge where `bus_we` is high. A read registers its data at the edge where `bus_re` is high, and `bus_rdata` then holds that data until the next read. Registers are selected by a word index, which is the byte offset divided by four.

Top module: `rng_seq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and every register reads as 0.
- R2: The register map, by word index, is as follows. Index 0 holds word bits [31:0] and index 1 holds word bits [63:32]. Index 2 is status, with ready in bit 0. Index 3 is the mask, in bit 0. Index 4 is acknowledge, which is write-only and reads 0. Index 5 is control: run bit in bit 10, warm-up field in bits [31:16]. Index 6 is config: lower refill field in bits [7:0], divider D in bits [15:8], upper refill field in bits [31:16]. Reserved bits read 0. Writes to status are ignored, and index 7 reads 0.
- R3: The warm-up length is N×256 samples for a field value N of 1 or more. A field value of 0 gives 2^24 samples.
- R4: Samples are taken once every D+1 clocks. Suppose the run bit is written at edge E and the warm-up length is S samples. Then ready is first 1 after edge E+1+S·(D+1).
- R5: The word holds the last 64 samples. Bit 0 is the newest, and bit i is the sample taken i sample periods earlier.
- R6: Writing bit 0 = 1 to acknowledge at edge A while ready is set clears ready. Ready returns after edge A+T·(D+1). T is the smaller of two values: the larger of L and 64, or U. The lower bound L is N×64 and the upper bound U is N×256, where a field value of 0 gives 2^24 for either. Every bit of the new word is sampled after A.
- R7: While ready is set and the run bit stays 1, ready stays set and the word does not change.
- R8: An acknowledge write has no effect if ready is clear, or if bit 0 of the written data is 0.
- R9: `irq` is 1 exactly when ready and mask bit 0 are both 1.
- R10: Clearing the run bit drops ready within two clocks and returns the block to idle. Setting the run bit again starts a full warm-up, timed as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entropy_in | input | 1 | Raw noise bit, one per clock |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_idx | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on a read strobe |
| irq | output | 1 | Ready interrupt, gated by mask bit 0 |

## Verification
A miscounting sample counter or divider shows up as a ready edge on `irq` that arrives early or late by whole sample periods. This is visible the first time ready is due, so the bench samples `irq` on the clock before and the clock after the predicted edge. A shift register that loses or reorders bits corrupts the first word read after ready rises. A state machine stuck in the wrong phase shows as `irq` never rising, or as ready ignoring an acknowledge. Either appears within one warm-up or one refill period. The bench sweeps the divider, the warm-up length and six pairs of refill bounds, including zero-coded bounds.

// File: rtl/rng_seq_pkg.sv
package rng_seq_pkg;

    localparam int WORD_W   = 64;
    localparam int HALF_W   = WORD_W / 2;
    localparam int CNT_W    = 25;
    localparam int ZERO_EXP = 24;
    localparam int IDX_W    = 3;
    localparam int DIV_W    = 8;

    localparam int SH_WARM  = 8;
    localparam int SH_LOWER = 6;
    localparam int SH_UPPER = 8;

    localparam logic [IDX_W-1:0] IDX_WORD_LO = 3'd0;
    localparam logic [IDX_W-1:0] IDX_WORD_HI = 3'd1;
    localparam logic [IDX_W-1:0] IDX_STATUS  = 3'd2;
    localparam logic [IDX_W-1:0] IDX_MASK    = 3'd3;
    localparam logic [IDX_W-1:0] IDX_ACK     = 3'd4;
    localparam logic [IDX_W-1:0] IDX_CTRL    = 3'd5;
    localparam logic [IDX_W-1:0] IDX_CFG     = 3'd6;

    localparam int RUN_BIT = 10;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WARM   = 2'd1,
        PH_HOLD   = 2'd2,
        PH_REFILL = 2'd3
    } phase_t;

    typedef struct packed {
        logic [15:0] warm_n;
        logic        run;
    } ctrl_t;

    typedef struct packed {
        logic [15:0]      upper_n;
        logic [DIV_W-1:0] div;
        logic [7:0]       lower_n;
    } cfg_t;

    typedef struct packed {
        logic [CNT_W-1:0] warm;
        logic [CNT_W-1:0] lower;
        logic [CNT_W-1:0] upper;
    } limits_t;

    function automatic logic [CNT_W-1:0] decode_count(input logic [15:0] n, input int sh);
        logic [CNT_W-1:0] r;
        if (n == 16'd0) r = CNT_W'(1) << ZERO_EXP;
        else            r = CNT_W'(n) << sh;
        return r;
    endfunction

endpackage

// File: rtl/rng_sample_clock.sv
module rng_sample_clock
    import rng_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) cnt_q <= '0;
        else if (tick)              cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    AST_SAMPLE_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && div != '0 && !restart) |=> (!tick || div == '0)) else $error("sample gap"); // R4

endmodule

// File: rtl/rng_collector.sv
module rng_collector
    import rng_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_en,
    input  logic              tick,
    input  logic              noise,
    input  logic              ack,
    input  limits_t           lim,
    output logic              ready,
    output logic              active,
    output logic              restart,
    output logic [WORD_W-1:0] word
);

    localparam int FRESH_W = $clog2(WORD_W) + 1;

    phase_t              phase_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [FRESH_W-1:0]  fresh_q;
    logic [WORD_W-2:0]   hist_q;
    logic [WORD_W-1:0]   word_q;

    logic [CNT_W-1:0]    cnt_inc;
    logic [FRESH_W-1:0]  fresh_inc;
    logic [WORD_W-1:0]   window;
    logic                warm_done;
    logic                refill_done;

    assign cnt_inc     = cnt_q + 1'b1;
    assign fresh_inc   = (fresh_q == FRESH_W'(WORD_W)) ? fresh_q : fresh_q + 1'b1;
    assign window      = {hist_q, noise};
    assign warm_done   = cnt_inc >= lim.warm;
    assign refill_done = ((cnt_inc >= lim.lower) && (fresh_inc == FRESH_W'(WORD_W)))
                         || (cnt_inc >= lim.upper);

    assign ready   = (phase_q == PH_HOLD);
    assign active  = (phase_q != PH_IDLE);
    assign restart = ready && run_en && ack;
    assign word    = word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (tick) begin
            hist_q <= window[WORD_W-2:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            fresh_q <= '0;
            word_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (run_en) begin
                        phase_q <= PH_WARM;
                        cnt_q   <= '0;
                        fresh_q <= '0;
                    end
                end
                PH_WARM: begin
                    if (!run_en) begin
                        phase_q <= PH_IDLE;
                    end else if (tick) begin
                        cnt_q <= cnt_inc;
                        if (warm_done) begin
                            word_q  <= window;
                            phase_q <= PH_HOLD;
                        end
                    end
                end
                PH_HOLD: begin
                    if (!run_en) begin
                        phase_q <= PH_IDLE;
                    end else if (ack) begin
                        phase_q <= PH_REFILL;
                        cnt_q   <= '0;
                        fresh_q <= '0;
                    end
                end
                PH_REFILL: begin
                    if (!run_en) begin
                        phase_q <= PH_IDLE;
                    end else if (tick) begin
                        cnt_q   <= cnt_inc;
                        fresh_q <= fresh_inc;
                        if (refill_done) begin
                            word_q  <= window;
                            phase_q <= PH_HOLD;
                        end
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ready |=> $stable(word_q)) else $error("word changed while held"); // R7
    AST_READY_HELD: assert property (@(posedge clk) disable iff (rst)
        (ready && !ack && run_en) |=> ready) else $error("ready lost"); // R7
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst)
        (ready && ack) |=> !ready) else $error("ack ignored"); // R6
    AST_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !ready) else $error("ready while off"); // R10

endmodule

// File: rtl/rng_regfile.sv
module rng_regfile
    import rng_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [IDX_W-1:0]  bus_idx,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ready,
    input  logic [WORD_W-1:0] word,
    output ctrl_t             ctrl,
    output cfg_t              cfg,
    output logic              mask,
    output logic              ack
);

    ctrl_t       ctrl_q;
    cfg_t        cfg_q;
    logic        mask_q;
    logic [31:0] rdata_q;
    logic [31:0] rd_mux;

    assign ack = bus_we && (bus_idx == IDX_ACK) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            cfg_q  <= '0;
            mask_q <= 1'b0;
        end else if (bus_we) begin
            if (bus_idx == IDX_CTRL) begin
                ctrl_q.warm_n <= bus_wdata[31:16];
                ctrl_q.run    <= bus_wdata[RUN_BIT];
            end
            if (bus_idx == IDX_CFG)  cfg_q  <= cfg_t'(bus_wdata);
            if (bus_idx == IDX_MASK) mask_q <= bus_wdata[0];
        end
    end

    always_comb begin
        rd_mux = '0;
        unique case (bus_idx)
            IDX_WORD_LO: rd_mux = word[HALF_W-1:0];
            IDX_WORD_HI: rd_mux = word[WORD_W-1:HALF_W];
            IDX_STATUS:  rd_mux = {31'd0, ready};
            IDX_MASK:    rd_mux = {31'd0, mask_q};
            IDX_CTRL: begin
                rd_mux[31:16]   = ctrl_q.warm_n;
                rd_mux[RUN_BIT] = ctrl_q.run;
            end
            IDX_CFG:     rd_mux = 32'(cfg_q);
            default:     rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         rdata_q <= '0;
        else if (bus_re) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign ctrl      = ctrl_q;
    assign cfg       = cfg_q;
    assign mask      = mask_q;

    AST_STATUS_RO: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_idx == IDX_STATUS) |=> ($stable(ctrl_q) && $stable(cfg_q) && $stable(mask_q)))
        else $error("status write had effect"); // R2

endmodule

// File: rtl/rng_seq_ctrl.sv
module rng_seq_ctrl
    import rng_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        entropy_in,
    input  logic        bus_we,
    input  logic        bus_re,
    input  logic [2:0]  bus_idx,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    ctrl_t              ctrl;
    cfg_t               cfg;
    limits_t            lim;
    logic               mask;
    logic               ack;
    logic               ready;
    logic               active;
    logic               restart;
    logic               tick;
    logic [WORD_W-1:0]  word;

    always_comb begin
        lim.warm  = decode_count(ctrl.warm_n, SH_WARM);
        lim.lower = decode_count({8'd0, cfg.lower_n}, SH_LOWER);
        lim.upper = decode_count(cfg.upper_n, SH_UPPER);
    end

    rng_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ready     (ready),
        .word      (word),
        .ctrl      (ctrl),
        .cfg       (cfg),
        .mask      (mask),
        .ack       (ack)
    );

    rng_sample_clock u_div (
        .clk     (clk),
        .rst     (rst),
        .run     (active),
        .restart (restart),
        .div     (cfg.div),
        .tick    (tick)
    );

    rng_collector u_coll (
        .clk     (clk),
        .rst     (rst),
        .run_en  (ctrl.run),
        .tick    (tick),
        .noise   (entropy_in),
        .ack     (ack),
        .lim     (lim),
        .ready   (ready),
        .active  (active),
        .restart (restart),
        .word    (word)
    );

    assign irq = ready & mask;

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        !mask |-> !irq) else $error("irq while masked"); // R9
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (ready || $rose(mask))) else $error("irq without ready"); // R9

endmodule

// File: tb/rng_seq_ctrl_test.sv
`timescale 1ns/1ps
module rng_seq_ctrl_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ent;
    logic        we = 1'b0;
    logic        re = 1'b0;
    logic [2:0]  idx = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int unsigned cyc = 0;
    int unsigned last_edge = 0;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic ent_of(input int unsigned n);
        logic [31:0] h;
        h = n * 32'h9E3779B1;
        return ^h[31:13];
    endfunction

    assign ent = ent_of(cyc);

    rng_seq_ctrl uut (
        .clk(clk), .rst(rst), .entropy_in(ent),
        .bus_we(we), .bus_re(re), .bus_idx(idx),
        .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
    );

    function automatic logic [63:0] exp_word(input int unsigned last, input int unsigned step);
        logic [63:0] w;
        for (int i = 0; i < 64; i++) w[i] = ent_of(last - i * step);
        return w;
    endfunction

    function automatic int unsigned refill_len(input int unsigned lo_n, input int unsigned up_n);
        int unsigned lo, up;
        lo = (lo_n == 0) ? (1 << 24) : lo_n * 64;
        up = (up_n == 0) ? (1 << 24) : up_n * 256;
        if (lo < 64) lo = 64;
        return (lo < up) ? lo : up;
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        we = 1'b1; idx = i; wdata = d; last_edge = cyc;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] d);
        re = 1'b1; idx = i;
        @(negedge clk);
        re = 1'b0;
        d = rdata;
    endtask

    task automatic wait_cyc(input int unsigned n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        wait (cyc >= 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual cycle %0d expected completion before it", cyc);
        finish_run();
    end

    initial begin
        logic [31:0] v, lo, hi;
        logic [63:0] ew;
        int unsigned r, a, t;
        int unsigned lo_n [6] = '{1, 3, 5, 0, 1, 2};
        int unsigned up_n [6] = '{1, 2, 1, 1, 0, 3};

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq", irq, 0);
        for (int i = 0; i < 8; i++) begin
            rd(3'(i), v);
            chk("R1 reg", v, 0);
        end

        // R2: readback, reserved bits, status and ack
        wr(3'd5, 32'hFFFF_FBFF);
        rd(3'd5, v); chk("R2 ctrl", v, 32'hFFFF_0000);
        wr(3'd5, 32'h0);
        wr(3'd6, 32'hABCD_EF12);
        rd(3'd6, v); chk("R2 cfg", v, 32'hABCD_EF12);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3, v); chk("R2 mask", v, 1);
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2, v); chk("R2 status write", v, 0);
        chk("R2 irq", irq, 0);
        rd(3'd4, v); chk("R2 ack read", v, 0);
        rd(3'd7, v); chk("R2 unmapped", v, 0);

        // R3: zero warm-up field means 2^24 samples
        wr(3'd6, {16'd1, 8'd0, 8'd1});
        wr(3'd5, {16'd0, 5'd0, 1'b1, 10'd0});
        repeat (3000) @(negedge clk);
        rd(3'd2, v); chk("R3 zero warm-up", v, 0);
        wr(3'd5, 32'h0);
        repeat (3) @(negedge clk);

        for (int d = 0; d < 3; d++) begin
            for (int s = 1; s <= 2; s++) begin
                logic msk;
                msk = (d == 1 && s == 2) ? 1'b0 : 1'b1;
                wr(3'd6, {16'd1, 8'(d), 8'd1});
                wr(3'd3, {31'd0, msk});
                wr(3'd5, {16'(s), 5'd0, 1'b1, 10'd0});
                r = last_edge + 1 + s * 256 * (d + 1);
                wait_cyc(r);
                chk("R3 R4 R10 early", irq, 0);
                wait_cyc(r + 1);
                chk("R3 R4 R9 rise", irq, msk);
                rd(3'd2, v); chk("R4 status", v, 1);
                ew = exp_word(r, d + 1);
                rd(3'd0, lo); rd(3'd1, hi);
                chk("R5 word", {hi, lo}, ew);

                if (d == 0 && s == 1) begin
                    wr(3'd3, 0); chk("R9 masked", irq, 0);
                    wr(3'd3, 1); chk("R9 unmasked", irq, 1);
                end

                for (int p = 0; p < 6; p++) begin
                    wr(3'd6, {16'(up_n[p]), 8'(d), 8'(lo_n[p])});
                    repeat (5) @(negedge clk);
                    rd(3'd0, lo); rd(3'd1, hi);
                    chk("R7 frozen", {hi, lo}, ew);
                    wr(3'd4, 32'hFFFF_FFFE);
                    rd(3'd2, v); chk("R8 bit0 zero", v, 1);
                    wr(3'd4, 32'h1);
                    a = last_edge;
                    t = refill_len(lo_n[p], up_n[p]);
                    r = a + t * (d + 1);
                    wr(3'd4, 32'h1);
                    rd(3'd2, v); chk("R6 cleared", v, 0);
                    wait_cyc(r);
                    chk("R6 R8 early", irq, 0);
                    wait_cyc(r + 1);
                    chk("R6 R9 rise", irq, msk);
                    rd(3'd2, v); chk("R6 status", v, 1);
                    ew = exp_word(r, d + 1);
                    rd(3'd0, lo); rd(3'd1, hi);
                    chk("R5 R6 word", {hi, lo}, ew);
                end

                wr(3'd5, 32'h0);
                repeat (2) @(negedge clk);
                chk("R10 irq off", irq, 0);
                rd(3'd2, v); chk("R10 idle", v, 0);
            end
        end

        finish_run();
    end

endmodule